// File: doc/BRIEF.md
# HDLC Frame Serialiser

This block turns a stream of characters into bit-oriented synchronous frames on a single serial line. A frame can begin with an optional pad character, which is sent as is. An opening flag follows, then the characters, least significant bit first, with a zero inserted after every run of five ones. The frame ends with a 16-bit frame check sequence and a closing flag. Every character carries its own end-of-frame mark. A final character can be cut to between one and seven bits.

The line advances one bit for each cycle in which `bit_en` is high. When no frame is in progress, the line idles at mark or sends flags back to back. When the two frames are back to back, the closing flag of one frame can also serve as the opening flag of the next. An underrun occurs when a character is needed in the middle of a frame and none is offered. On underrun the block closes the line in one of three programmable ways. Clearing `enable` forces the line to mark and resets the sequencer.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While `enable` is low, `txd` is 1 and no character is accepted (`ch_ready` stays 0).
- R2: With `cfg_idle_flags`=0 and no frame pending, `txd` stays at 1.
- R3: With `cfg_idle_flags`=1 and no frame pending, the line carries back-to-back flags, each being the bits 0,1,1,1,1,1,1,0.
- R4: A frame consists of the opening flag, the character bits (each character least significant bit first), the check sequence and a closing flag, in that order.
- R5: In the character and check-sequence bits, a 0 is inserted after every five consecutive 1s. The count carries across character boundaries and into the check sequence. A pending inserted 0 is sent before the closing flag or abort.
- R6: The check sequence is a CRC with reflected polynomial 0x8408 and preset 0xFFFF. It is computed over the sent character bits (not over inserted zeros), complemented, and sent bit 0 first, so the low byte goes first.
- R7: A character with `ch_eof`=1 ends the frame. When its `ch_resid` is 1..7, only that many low bits are sent; when `ch_resid` is 0, all 8 bits are sent. `ch_resid` is ignored when `ch_eof`=0.
- R8: With `cfg_share_flag`=1, a frame that is ready when a closing flag ends starts its characters directly after that flag. With `cfg_share_flag`=0, a second, separate opening flag is sent first.
- R9: Underrun with `cfg_fill_mode`=0 (or 3) sends eight 1s without zero insertion, then returns to the idle behaviour.
- R10: Underrun with `cfg_fill_mode`=1 sends eight 1s, then flags until the next frame begins.
- R11: Underrun with `cfg_fill_mode`=2 sends the check sequence of the characters sent so far and a closing flag, then flags until the next frame begins.
- R12: With `cfg_pad_en`=1, a frame that starts from idle is preceded by the 8 bits of `cfg_pad_char`, least significant bit first, with no zero insertion.
- R13: `txd` changes only after a clock edge with `bit_en` high. `ch_ready` is high only while `ch_valid` is high, and a character is taken on a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable; low forces mark and resets the sequencer |
| bit_en | input | 1 | Advance the line by one bit on this clock |
| cfg_idle_flags | input | 1 | Idle with flags (1) or mark (0) |
| cfg_share_flag | input | 1 | Let one flag both close a frame and open the next |
| cfg_pad_en | input | 1 | Send a pad character before the opening flag |
| cfg_pad_char | input | 8 | Pad character value |
| cfg_fill_mode | input | 2 | Underrun fill: 0/3 abort, 1 abort then flags, 2 check sequence then flags |
| ch_valid | input | 1 | A character is offered |
| ch_data | input | 8 | Character bits |
| ch_eof | input | 1 | This character ends the frame |
| ch_resid | input | 3 | Bit count of the final character (0 means 8) |
| ch_ready | output | 1 | Character taken on this clock |
| txd | output | 1 | Serial data out |

## Verification
Two things can fall in the same bit step. One is the zero inserted after five ones. The other is the change from one field to the next, whether from character to check sequence, from check sequence to closing flag, or from character to abort. The bench sets up these cases with characters whose last bits are runs of ones (0x1F cut to five bits, 0xFF, 0x7F cut to seven bits). It checks that the inserted zero comes out before the flag and that the check sequence covers only the real data bits. The bench also checks the pairing of a character handshake with a slow `bit_en`. It runs frames at bit rates of one, one half and one third of the clock and checks that `txd` never moves between strobes.

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx #(
  parameter int          CHAR_W   = 8,
  parameter int          FCS_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [7:0]  FLAG_PAT = 8'h7E,
  parameter int          RUN_MAX  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_en,
  input  logic              cfg_idle_flags,
  input  logic              cfg_share_flag,
  input  logic              cfg_pad_en,
  input  logic [CHAR_W-1:0] cfg_pad_char,
  input  logic [1:0]        cfg_fill_mode,
  input  logic              ch_valid,
  input  logic [CHAR_W-1:0] ch_data,
  input  logic              ch_eof,
  input  logic [$clog2(CHAR_W)-1:0] ch_resid,
  output logic              ch_ready,
  output logic              txd
);
  localparam int RES_W = $clog2(CHAR_W);
  localparam int CNT_W = $clog2(FCS_W + 1);
  localparam int ONE_W = $clog2(RUN_MAX + 1);

  typedef enum logic [2:0] {S_MARK, S_PAD, S_FLAG, S_DATA, S_FCS, S_ABORT} st_t;
  typedef enum logic [2:0] {A_NONE, A_MARK, A_PAD, A_OPEN, A_FLAG, A_CHAR, A_FCS, A_ABORT} act_t;

  st_t              st, st_n;
  act_t             act;
  logic [FCS_W-1:0] sh, sh_n, crc, crc_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [ONE_W-1:0] ones, ones_n;
  logic             fl_open, fl_open_n;
  logic             cur_eof, cur_eof_n;
  logic             fillf, fillf_n;
  logic             take;

  wire stuffed = (st == S_DATA) || (st == S_FCS);
  wire ins     = stuffed && (ones == ONE_W'(RUN_MAX));
  wire out_bit = (st == S_MARK) || (!ins && sh[0]);
  wire step    = enable && bit_en;

  wire [CNT_W-1:0] cnt_dec   = ins ? cnt : cnt - 1'b1;
  wire [ONE_W-1:0] ones_step = (!stuffed || ins || !sh[0]) ? '0 : ones + 1'b1;
  wire             done      = (cnt_dec == '0) && !(stuffed && ones_step == ONE_W'(RUN_MAX));
  wire [FCS_W-1:0] crc_shift = (crc >> 1) ^ ((crc[0] ^ sh[0]) ? CRC_POLY : '0);
  wire [FCS_W-1:0] crc_upd   = (st == S_DATA && !ins) ? crc_shift : crc;
  wire [FCS_W-1:0] sh_shift  = ins ? sh : (sh >> 1);
  wire             no_more   = !(cfg_idle_flags || fillf);
  wire [CNT_W-1:0] char_len  = (ch_eof && ch_resid != '0) ? CNT_W'(ch_resid) : CNT_W'(CHAR_W);

  act_t start_act, under_act, end_act;
  assign start_act = cfg_pad_en ? A_PAD : A_OPEN;
  assign under_act = (cfg_fill_mode == 2'd2) ? A_FCS : A_ABORT;
  assign end_act   = ch_valid ? ((cfg_share_flag && st == S_FLAG) ? A_CHAR : start_act)
                              : (no_more ? A_MARK : A_FLAG);

  always_comb begin
    act = A_NONE;
    if (done) begin
      unique case (st)
        S_MARK:  act = ch_valid ? start_act : (cfg_idle_flags ? A_FLAG : A_MARK);
        S_PAD:   act = A_OPEN;
        S_FLAG:  act = fl_open ? (ch_valid ? A_CHAR : under_act) : end_act;
        S_DATA:  act = cur_eof ? A_FCS : (ch_valid ? A_CHAR : under_act);
        S_FCS:   act = A_FLAG;
        S_ABORT: act = end_act;
        default: act = A_MARK;
      endcase
    end
  end

  always_comb begin
    st_n      = st;
    sh_n      = sh_shift;
    cnt_n     = cnt_dec;
    ones_n    = ones_step;
    crc_n     = crc_upd;
    fl_open_n = fl_open;
    cur_eof_n = cur_eof;
    fillf_n   = fillf;
    take      = 1'b0;
    unique case (act)
      A_MARK: begin
        st_n = S_MARK; cnt_n = CNT_W'(1); ones_n = '0; crc_n = CRC_INIT;
      end
      A_PAD: begin
        st_n = S_PAD; sh_n = FCS_W'(cfg_pad_char); cnt_n = CNT_W'(CHAR_W);
        ones_n = '0; crc_n = CRC_INIT; fillf_n = 1'b0;
      end
      A_OPEN: begin
        st_n = S_FLAG; sh_n = FCS_W'(FLAG_PAT); cnt_n = CNT_W'(8);
        ones_n = '0; crc_n = CRC_INIT; fl_open_n = 1'b1; fillf_n = 1'b0;
      end
      A_FLAG: begin
        st_n = S_FLAG; sh_n = FCS_W'(FLAG_PAT); cnt_n = CNT_W'(8);
        ones_n = '0; crc_n = CRC_INIT; fl_open_n = 1'b0;
      end
      A_CHAR: begin
        st_n = S_DATA; sh_n = FCS_W'(ch_data); cnt_n = char_len;
        cur_eof_n = ch_eof; fillf_n = 1'b0; take = 1'b1;
      end
      A_FCS: begin
        st_n = S_FCS; sh_n = ~crc_upd; cnt_n = CNT_W'(FCS_W);
        if (st == S_DATA && !cur_eof) fillf_n = 1'b1;
      end
      A_ABORT: begin
        st_n = S_ABORT; sh_n = FCS_W'(8'hFF); cnt_n = CNT_W'(8); ones_n = '0;
        fillf_n = (cfg_fill_mode == 2'd1);
      end
      default: ;
    endcase
  end

  assign ch_ready = step && take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_MARK; sh <= '0; cnt <= CNT_W'(1); ones <= '0; crc <= CRC_INIT;
      fl_open <= 1'b0; cur_eof <= 1'b0; fillf <= 1'b0; txd <= 1'b1;
    end else if (!enable) begin
      st <= S_MARK; sh <= '0; cnt <= CNT_W'(1); ones <= '0; crc <= CRC_INIT;
      fl_open <= 1'b0; cur_eof <= 1'b0; fillf <= 1'b0; txd <= 1'b1;
    end else if (bit_en) begin
      st <= st_n; sh <= sh_n; cnt <= cnt_n; ones <= ones_n; crc <= crc_n;
      fl_open <= fl_open_n; cur_eof <= cur_eof_n; fillf <= fillf_n; txd <= out_bit;
    end
  end

  // R1
  disabled_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> txd);
  // R13
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready |-> ch_valid);
  // R13
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bit_en) |=> $stable(txd));
  // R5
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ins) |=> !txd);
  // R9
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == S_ABORT) |=> txd);
  // R2
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == S_MARK) |=> txd);
endmodule

// File: tb/tb_hdlc_frame_tx.sv
module tb_hdlc_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, bit_en = 1'b0;
  logic cfg_idle_flags = 1'b0, cfg_share_flag = 1'b0, cfg_pad_en = 1'b0;
  logic [7:0] cfg_pad_char = 8'h00;
  logic [1:0] cfg_fill_mode = 2'd0;
  logic ch_valid = 1'b0, ch_eof = 1'b0;
  logic [7:0] ch_data = 8'h00;
  logic [2:0] ch_resid = 3'd0;
  logic ch_ready, txd;

  always #2 clk = ~clk;

  hdlc_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en),
    .cfg_idle_flags(cfg_idle_flags), .cfg_share_flag(cfg_share_flag),
    .cfg_pad_en(cfg_pad_en), .cfg_pad_char(cfg_pad_char), .cfg_fill_mode(cfg_fill_mode),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_eof(ch_eof), .ch_resid(ch_resid),
    .ch_ready(ch_ready), .txd(txd)
  );

  logic acc = 1'b0;
  always @(posedge clk) acc <= ch_valid & ch_ready;

  // n[47:45] resid[44:42] div[41:40] data[31:0], byte 0 first
  localparam logic [47:0] ROWS [0:7] = '{
    {3'd1, 3'd0, 2'd1, 8'h00, 32'h00000055},
    {3'd2, 3'd0, 2'd1, 8'h00, 32'h000001FF},
    {3'd3, 3'd0, 2'd2, 8'h00, 32'h003F7E7E},
    {3'd4, 3'd0, 2'd1, 8'h00, 32'h1FF83412},
    {3'd2, 3'd5, 2'd1, 8'h00, 32'h00001FAA},
    {3'd1, 3'd3, 2'd3, 8'h00, 32'h00000007},
    {3'd3, 3'd1, 2'd1, 8'h00, 32'h00FF0FF0},
    {3'd4, 3'd7, 2'd2, 8'h00, 32'h7F3C81E7}
  };

  int checks = 0, fails = 0, cyc = 0, viol_hold = 0, viol_rdy = 0;
  int nrec = 0, ne = 0, eones = 0, divn = 1, divcnt = 0;
  int q_n = 0, q_rd = 0;
  logic rec = 1'b0, txd_prev = 1'b1;
  logic stream [0:2047];
  logic expb [0:511];
  logic [15:0] ecrc;
  logic [7:0] q_data [0:15];
  logic       q_eof  [0:15];
  logic [2:0] q_res  [0:15];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (rst_n && !bit_en && txd !== txd_prev) viol_hold++;
    if (ch_ready && !ch_valid) viol_rdy++;
    txd_prev = txd;
    if (bit_en && rec && nrec < 2048) begin stream[nrec] = txd; nrec++; end
    if (acc) q_rd++;
    bit_en = (divcnt == 0);
    divcnt = (divcnt + 1 >= divn) ? 0 : divcnt + 1;
    ch_valid = (q_rd < q_n);
    ch_data  = (q_rd < q_n) ? q_data[q_rd] : 8'h00;
    ch_eof   = (q_rd < q_n) ? q_eof[q_rd] : 1'b0;
    ch_resid = (q_rd < q_n) ? q_res[q_rd] : 3'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rec = 1'b0; q_n = 0; q_rd = 0; divcnt = 0;
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    tick();
    nrec = 0; rec = 1'b1;
  endtask

  task automatic enq(input logic [7:0] d, input logic e, input logic [2:0] r);
    q_data[q_n] = d; q_eof[q_n] = e; q_res[q_n] = r; q_n++;
  endtask

  task automatic run_bits(input int n);
    while (nrec < n) tick();
  endtask

  task automatic e_start(); ne = 0; eones = 0; ecrc = 16'hFFFF; endtask
  task automatic e_bit(input logic b); expb[ne] = b; ne++; endtask
  task automatic e_raw(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) e_bit(v[i]);
  endtask
  task automatic e_flag(); e_raw(8'h7E, 8); eones = 0; ecrc = 16'hFFFF; endtask
  task automatic e_sbit(input logic b);
    e_bit(b);
    eones = b ? eones + 1 : 0;
    if (eones == 5) begin e_bit(1'b0); eones = 0; end
  endtask
  task automatic e_data(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = ecrc[0] ^ v[i];
      ecrc = (ecrc >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      e_sbit(v[i]);
    end
  endtask
  task automatic e_fcs();
    logic [15:0] f;
    f = ~ecrc;
    for (int i = 0; i < 16; i++) e_sbit(f[i]);
    eones = 0;
  endtask

  function automatic int find_exp();
    for (int s = 0; s + ne <= nrec; s++) begin
      logic m;
      m = 1'b1;
      for (int k = 0; k < ne; k++) if (stream[s+k] !== expb[k]) m = 1'b0;
      if (m) return s;
    end
    return -1;
  endfunction

  initial begin
    int idx;
    // reset state (R1, R13)
    rst_n = 1'b0;
    tick(); tick();
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(ch_ready === 1'b0, "R13 reset ready", ch_ready, 0);

    // table of frames: R4 R5 R6 R7
    for (int r = 0; r < 8; r++) begin
      logic [47:0] row;
      int n, res;
      row = ROWS[r];
      n = row[47:45]; res = row[44:42]; divn = row[41:40];
      cfg_idle_flags = 0; cfg_share_flag = 0; cfg_pad_en = 0; cfg_fill_mode = 0;
      do_reset();
      for (int b = 0; b < n; b++)
        enq(row[b*8 +: 8], b == n-1, (b == n-1) ? 3'(res) : 3'd0);
      run_bits(170);
      e_start(); e_flag();
      for (int b = 0; b < n; b++) e_data(row[b*8 +: 8], (b == n-1 && res != 0) ? res : 8);
      e_fcs(); e_flag();
      idx = find_exp();
      chk(idx >= 0, $sformatf("R4 R5 R6 R7 frame row %0d", r), idx, 0);
      chk(q_rd == n, $sformatf("R13 chars taken row %0d", r), q_rd, n);
      if (r == 0) begin
        int ones_tail;
        ones_tail = 0;
        for (int k = nrec - 24; k < nrec; k++) if (stream[k] === 1'b1) ones_tail++;
        chk(ones_tail == 24, "R2 idle mark after frame", ones_tail, 24);
      end
    end
    divn = 1;

    // disabled: R1
    enable = 1'b0;
    do_reset();
    enq(8'h00, 1'b1, 3'd0);
    run_bits(60);
    begin
      int zeros;
      zeros = 0;
      for (int k = 0; k < nrec; k++) if (stream[k] !== 1'b1) zeros++;
      chk(zeros == 0, "R1 disabled line mark", zeros, 0);
      chk(q_rd == 0, "R1 disabled no accept", q_rd, 0);
    end
    enable = 1'b1;

    // idle flags: R3
    cfg_idle_flags = 1'b1;
    do_reset();
    run_bits(60);
    e_start(); e_flag(); e_flag(); e_flag();
    idx = find_exp();
    chk(idx >= 0, "R3 idle flags", idx, 0);
    cfg_idle_flags = 1'b0;

    // shared flag on: R8
    cfg_share_flag = 1'b1;
    do_reset();
    enq(8'h11, 1'b1, 3'd0); enq(8'h22, 1'b1, 3'd0);
    run_bits(160);
    e_start(); e_flag(); e_data(8'h11, 8); e_fcs(); e_flag(); e_data(8'h22, 8); e_fcs(); e_flag();
    idx = find_exp();
    chk(idx >= 0, "R8 shared flag", idx, 0);

    // shared flag off: R8
    cfg_share_flag = 1'b0;
    do_reset();
    enq(8'h11, 1'b1, 3'd0); enq(8'h22, 1'b1, 3'd0);
    run_bits(170);
    e_start(); e_flag(); e_data(8'h11, 8); e_fcs(); e_flag(); e_flag(); e_data(8'h22, 8); e_fcs(); e_flag();
    idx = find_exp();
    chk(idx >= 0, "R8 separate flags", idx, 0);

    // pad: R12
    cfg_pad_en = 1'b1; cfg_pad_char = 8'hBF;
    do_reset();
    enq(8'h5A, 1'b1, 3'd0);
    run_bits(120);
    e_start(); e_raw(8'hBF, 8); e_flag(); e_data(8'h5A, 8); e_fcs(); e_flag();
    idx = find_exp();
    chk(idx >= 0, "R12 opening pad", idx, 0);
    cfg_pad_en = 1'b0;

    // underrun fills: R9 R10 R11
    for (int m = 0; m < 3; m++) begin
      cfg_fill_mode = 2'(m);
      do_reset();
      enq(8'h3C, 1'b0, 3'd0); enq(8'h81, 1'b0, 3'd0);
      run_bits(140);
      e_start(); e_flag(); e_data(8'h3C, 8); e_data(8'h81, 8);
      if (m == 0) begin e_raw(8'hFF, 8); e_raw(8'hFF, 8); e_raw(8'hFF, 8); end
      else if (m == 1) begin e_raw(8'hFF, 8); e_flag(); e_flag(); end
      else begin e_fcs(); e_flag(); e_flag(); end
      idx = find_exp();
      if (m == 0) chk(idx >= 0, "R9 abort fill", idx, 0);
      else if (m == 1) chk(idx >= 0, "R10 abort then flags", idx, 0);
      else chk(idx >= 0, "R11 fcs then flags", idx, 0);
    end
    cfg_fill_mode = 2'd0;

    // R13 monitors over the whole run
    chk(viol_hold == 0, "R13 txd moved without bit_en", viol_hold, 0);
    chk(viol_rdy == 0, "R13 ready without valid", viol_rdy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule